// File: doc/BRIEF.md
# Critical-Word-First Burst Beat Sequencer

This block turns one memory request into a fixed-length, wrapping DRAM data burst. A request names the double word that must come first, how many double words are wanted, the direction, and whether the burst is four or eight beats long. Whatever the requested size, the block always runs a complete burst. The beat sequence starts at the requested double word and wraps inside the burst. Each beat carries a flag that says whether it belongs to the request, and on writes a write enable that blocks every beat outside the request. The DRAM data path uses these to leave the untouched double words in memory unchanged.

A request may not cross the end of the burst. A combination of size and offset that would cross it, or a size of zero, is refused with a one-cycle error pulse, and no beats are issued. Reads follow the same beat order and return every beat. The keep flag tells the consumer which returned beats carry requested data.

Top module: `wrap_burst_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `beat_valid` and `req_err` are 0.
- R2: While idle, `req_ready` is 1. A valid request accepted at a clock edge makes `beat_valid` high from the next cycle on, for exactly 4 consecutive cycles when `req_bl8`=0, or exactly 8 when `req_bl8`=1.
- R3: On beat k (counting from 0), `beat_idx` equals (`req_off` + k) mod B, where B is the burst length (4 or 8).
- R4: `beat_keep` is 1 on the first `req_size` beats of a burst and 0 on all later beats.
- R5: On a write (`req_write`=1), `beat_we` equals `beat_keep`. On a read, `beat_we` is 0 on every beat and all B beats are still issued.
- R6: A request is valid when `req_size` is at least 1 and `req_off` + `req_size` is at most B. For B=4 this allows size 1 at offsets 0 to 3, size 2 at offsets 0 to 2, size 3 at offsets 0 to 1, and size 4 at offset 0.
- R7: An invalid request is still accepted. It raises `req_err` for exactly one cycle, in the cycle after the handshake, produces no beats, and leaves `req_ready` at 1.
- R8: `beat_last` is 1 only on beat B-1. `req_ready` is 0 for the whole burst and returns to 1 in the cycle after the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_off | input | 3 | Double word to send first, within the burst |
| req_size | input | 4 | Number of double words requested |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bl8 | input | 1 | 1 = eight-beat burst, 0 = four-beat burst |
| req_err | output | 1 | One-cycle pulse when a request is refused |
| beat_valid | output | 1 | A burst beat is present |
| beat_idx | output | 3 | Double-word index within the burst for this beat |
| beat_keep | output | 1 | This beat carries requested data |
| beat_we | output | 1 | Write enable for this beat |
| beat_last | output | 1 | Final beat of the burst |

## Verification
The bench sweeps every offset from 0 to 7 and every size from 0 to 9, in both burst lengths and both directions, so that every legal start and every wrap point is tried. Sizes that exactly reach the burst end are run next to sizes one step beyond it, and offsets past the end of a four-beat burst are included. This separates a correct boundary check from an off-by-one check. Reads and writes with the same offset and size show whether the write enable follows the keep flag or is forced. Comparing the two burst lengths shows whether the wrap uses the selected burst length or a fixed one.

// File: rtl/wrap_burst_seq.sv
`timescale 1ns/1ps
module wrap_burst_seq #(
  parameter int SHORT_BL = 4,
  parameter int LONG_BL  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [$clog2(LONG_BL)-1:0]   req_off,
  input  logic [$clog2(LONG_BL):0]     req_size,
  input  logic                         req_write,
  input  logic                         req_bl8,
  output logic                         req_err,
  output logic                         beat_valid,
  output logic [$clog2(LONG_BL)-1:0]   beat_idx,
  output logic                         beat_keep,
  output logic                         beat_we,
  output logic                         beat_last
);
  localparam int IW = $clog2(LONG_BL);
  localparam int SW = IW + 1;
  localparam logic [IW-1:0] SHORT_MAX = IW'(SHORT_BL - 1);
  localparam logic [IW-1:0] LONG_MAX  = IW'(LONG_BL - 1);

  logic          busy, err_q, wr_q, long_q;
  logic [IW-1:0] off_q, cnt;
  logic [SW-1:0] size_q;

  wire [SW:0]    bl_in   = req_bl8 ? (SW+1)'(LONG_BL) : (SW+1)'(SHORT_BL);
  wire [SW:0]    end_in  = (SW+1)'(req_off) + (SW+1)'(req_size);
  wire           fits    = (req_size != '0) && (end_in <= bl_in);
  wire           accept  = req_valid && !busy;
  wire [IW-1:0]  wrap    = long_q ? LONG_MAX : SHORT_MAX;
  wire           at_end  = (cnt == wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      err_q  <= 1'b0;
      wr_q   <= 1'b0;
      long_q <= 1'b0;
      off_q  <= '0;
      size_q <= '0;
      cnt    <= '0;
    end else begin
      err_q <= accept && !fits;
      if (accept && fits) begin
        busy   <= 1'b1;
        cnt    <= '0;
        off_q  <= req_off;
        size_q <= req_size;
        wr_q   <= req_write;
        long_q <= req_bl8;
      end else if (busy) begin
        if (at_end) busy <= 1'b0;
        else        cnt  <= cnt + 1'b1;
      end
    end
  end

  assign req_ready  = !busy;
  assign req_err    = err_q;
  assign beat_valid = busy;
  assign beat_idx   = (off_q + cnt) & wrap;
  assign beat_keep  = busy && ({1'b0, cnt} < size_q);
  assign beat_we    = beat_keep && wr_q;
  assign beat_last  = busy && at_end;
endmodule

// File: rtl/wrap_burst_seq_chk.sv
`timescale 1ns/1ps
module wrap_burst_seq_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic [IW-1:0] req_off,
  input logic          req_err,
  input logic          beat_valid,
  input logic [IW-1:0] beat_idx,
  input logic          beat_keep,
  input logic          beat_we,
  input logic          beat_last
);
  // R3
  first_beat_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_valid) |-> (beat_idx == $past(req_off)));

  // R4
  first_beat_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_valid) |-> beat_keep);

  // R4
  keep_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_keep && !beat_last) |=> !beat_keep);

  // R5
  we_needs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_we |-> (beat_keep && beat_valid));

  // R7
  err_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!beat_valid && req_ready));

  // R8
  last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> (!beat_valid && req_ready));

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);
endmodule

bind wrap_burst_seq wrap_burst_seq_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_off(req_off),
  .req_err(req_err), .beat_valid(beat_valid), .beat_idx(beat_idx),
  .beat_keep(beat_keep), .beat_we(beat_we), .beat_last(beat_last)
);

// File: tb/sim_wrap_burst_seq.sv
`timescale 1ns/1ps
module sim_wrap_burst_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_off = '0;
  logic [3:0] req_size = '0;
  logic       req_write = 1'b0;
  logic       req_bl8 = 1'b0;
  logic       req_err, beat_valid, beat_keep, beat_we, beat_last;
  logic [2:0] beat_idx;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wrap_burst_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_off(req_off), .req_size(req_size), .req_write(req_write),
    .req_bl8(req_bl8), .req_err(req_err), .beat_valid(beat_valid),
    .beat_idx(beat_idx), .beat_keep(beat_keep), .beat_we(beat_we),
    .beat_last(beat_last)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual=%0d expected=%0d (bl8=%0d off=%0d size=%0d wr=%0d)",
               tag, act, exp, req_bl8, req_off, req_size, req_write);
    end
  endtask

  task automatic run(input int bl8, input int off, input int size, input int wr);
    int bl;
    bit ok;
    bl = bl8 ? 8 : 4;
    ok = (size >= 1) && (off + size <= bl);
    @(negedge clk);
    req_bl8 = bl8[0]; req_off = off[2:0]; req_size = size[3:0];
    req_write = wr[0]; req_valid = 1'b1;
    chk("R2 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (ok) begin
      for (int k = 0; k < bl; k++) begin
        chk("R2 beat_valid", beat_valid, 1);
        chk("R3 beat_idx", beat_idx, (off + k) % bl);
        chk("R4 beat_keep", beat_keep, (k < size) ? 1 : 0);
        chk("R5 beat_we", beat_we, (wr != 0 && k < size) ? 1 : 0);
        chk("R8 beat_last", beat_last, (k == bl - 1) ? 1 : 0);
        chk("R8 ready low in burst", req_ready, 0);
        chk("R6 no err on valid", req_err, 0);
        if (k < bl - 1) @(negedge clk);
      end
      @(negedge clk);
      chk("R2 burst length ends", beat_valid, 0);
      chk("R8 ready after last", req_ready, 1);
    end else begin
      chk("R7 err pulse", req_err, 1);
      chk("R7 no beats", beat_valid, 0);
      chk("R7 ready stays", req_ready, 1);
      @(negedge clk);
      chk("R7 err one cycle", req_err, 0);
      chk("R7 still no beats", beat_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 beat_valid", beat_valid, 0);
    chk("R1 req_err", req_err, 0);
    rst_n = 1'b1;
    for (int b = 0; b < 2; b++)
      for (int o = 0; o < 8; o++)
        for (int s = 0; s < 10; s++)
          for (int w = 0; w < 2; w++)
            run(b, o, s, w);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule